// File: doc/BRIEF.md
# Elastic Token Steering Operators

This block gathers four token-level operators of a dataflow datapath, each on its own group of valid/ready channels. A steering switch sends a group of value tokens to one of two sides, picked by a single control token. A selected joiner takes one token from one of two inputs, picked by a control token. A first-come joiner takes no control and passes whichever input holds a token. A strict adder waits for both operands and hands one identical copy of the sum to each of several consumers.

A token moves on a channel in any cycle where valid and ready are both high. While valid is high and ready is low, a producer holds its data. The steering switch and both joiners are purely combinational. They fire in the same cycle their tokens and the downstream ready line up. The adder registers its sum. It runs a two-state machine: `FO_IDLE` waits for both operands. The transition `fire` captures the sum and moves to `FO_EMIT`, which presents copies. The transition `finish` returns to `FO_IDLE` in the cycle the last outstanding copy is accepted.

Top module: `tok_steer_top`

## Requirements
- R1: After reset the adder is in its idle state, so every fan-out output valid is low.
- R2: The adder consumes its two operands together. Both operand readies rise only in a cycle where both operand valids are high, and neither operand is ever consumed alone.
- R3: The steering switch sends the value group to the true side when the control data bit is 1 and to the false side when it is 0. Both sides carry the value data unchanged, and the two side valids are never high together.
- R4: The steering switch fires only when every value lane valid and the control valid are high. On firing it consumes one token from each lane and from the control channel in the same cycle.
- R5: The steering switch consumes nothing while the side picked by the control is not ready, even if the other side is ready.
- R6: The selected joiner takes from input 0 when its control data bit is 0 and from input 1 when it is 1. It forwards that data, consumes the control token in the same cycle, and never raises ready on the input that was not picked.
- R7: The first-come joiner raises its output valid when either input holds a token and forwards that token. When both hold tokens, input 0 is forwarded and consumed first, and input 1 stays pending for a later cycle.
- R8: One cycle after firing, the adder presents the sum of the operands modulo 2^W on every fan-out output. Each output delivers exactly one copy per firing, and an unaccepted copy stays valid with stable data.
- R9: The adder accepts no new operands until every fan-out output has accepted its copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_val_d | input | NV*W | Value lane data of the steering switch |
| br_val_v | input | NV | Value lane valids |
| br_val_rdy | output | NV | Value lane readies |
| br_ctl_d | input | 1 | Steering control bit (1 = true side) |
| br_ctl_v | input | 1 | Steering control valid |
| br_ctl_rdy | output | 1 | Steering control ready |
| br_t_d | output | NV*W | True side data |
| br_t_v | output | 1 | True side valid |
| br_t_rdy | input | 1 | True side ready |
| br_f_d | output | NV*W | False side data |
| br_f_v | output | 1 | False side valid |
| br_f_rdy | input | 1 | False side ready |
| dm_in0_d | input | W | Selected joiner input 0 data |
| dm_in0_v | input | 1 | Input 0 valid |
| dm_in0_rdy | output | 1 | Input 0 ready |
| dm_in1_d | input | W | Selected joiner input 1 data |
| dm_in1_v | input | 1 | Input 1 valid |
| dm_in1_rdy | output | 1 | Input 1 ready |
| dm_sel_d | input | 1 | Joiner control bit (0 = input 0) |
| dm_sel_v | input | 1 | Joiner control valid |
| dm_sel_rdy | output | 1 | Joiner control ready |
| dm_out_d | output | W | Selected joiner output data |
| dm_out_v | output | 1 | Selected joiner output valid |
| dm_out_rdy | input | 1 | Selected joiner output ready |
| nd_in0_d | input | W | First-come joiner input 0 data |
| nd_in0_v | input | 1 | Input 0 valid |
| nd_in0_rdy | output | 1 | Input 0 ready |
| nd_in1_d | input | W | First-come joiner input 1 data |
| nd_in1_v | input | 1 | Input 1 valid |
| nd_in1_rdy | output | 1 | Input 1 ready |
| nd_out_d | output | W | First-come joiner output data |
| nd_out_v | output | 1 | First-come joiner output valid |
| nd_out_rdy | input | 1 | First-come joiner output ready |
| fo_a_d | input | W | Adder operand A data |
| fo_a_v | input | 1 | Operand A valid |
| fo_a_rdy | output | 1 | Operand A ready |
| fo_b_d | input | W | Adder operand B data |
| fo_b_v | input | 1 | Operand B valid |
| fo_b_rdy | output | 1 | Operand B ready |
| fo_out_d | output | W | Sum shared by all fan-out outputs |
| fo_out_v | output | NF | Per-output copy valid |
| fo_out_rdy | input | NF | Per-output consumer ready |

## Verification
The steering switch and both joiners answer in the same cycle. The bench drives their inputs just after a falling edge and samples their outputs two nanoseconds later, before the next rising edge. The adder's copies are due one rising edge after the operand handshake. Each later copy is observed in the cycle its consumer ready is high, so the bench samples them after the falling edge of each following cycle and tallies copies per output until every consumer holds exactly one. The bench also keeps operands valid throughout the emit state, which shows that operand ready stays low until the last copy is taken.

// File: rtl/tok_pkg.sv
package tok_pkg;
    typedef enum logic {
        FO_IDLE = 1'b0,
        FO_EMIT = 1'b1
    } fo_state_t;
endpackage

// File: rtl/tok_branch.sv
module tok_branch #(
    parameter int W  = 8,
    parameter int NV = 2
) (
    input  logic [NV-1:0][W-1:0] val_d,
    input  logic [NV-1:0]        val_v,
    output logic [NV-1:0]        val_rdy,
    input  logic                 ctl_d,
    input  logic                 ctl_v,
    output logic                 ctl_rdy,
    output logic [NV-1:0][W-1:0] t_d,
    output logic                 t_v,
    input  logic                 t_rdy,
    output logic [NV-1:0][W-1:0] f_d,
    output logic                 f_v,
    input  logic                 f_rdy
);
    logic armed;
    logic side_rdy;
    logic fire;

    always_comb begin
        armed    = (&val_v) & ctl_v;
        side_rdy = ctl_d ? t_rdy : f_rdy;
        fire     = armed & side_rdy;
        t_v      = armed & ctl_d;
        f_v      = armed & ~ctl_d;
        ctl_rdy  = fire;
    end

    for (genvar i = 0; i < NV; i++) begin : g_lane
        assign t_d[i]     = val_d[i];
        assign f_d[i]     = val_d[i];
        assign val_rdy[i] = fire;
    end
endmodule

// File: rtl/tok_dmerge.sv
module tok_dmerge #(
    parameter int W = 8
) (
    input  logic [W-1:0] in0_d,
    input  logic         in0_v,
    output logic         in0_rdy,
    input  logic [W-1:0] in1_d,
    input  logic         in1_v,
    output logic         in1_rdy,
    input  logic         sel_d,
    input  logic         sel_v,
    output logic         sel_rdy,
    output logic [W-1:0] out_d,
    output logic         out_v,
    input  logic         out_rdy
);
    logic fire;

    always_comb begin
        out_v   = sel_v & (sel_d ? in1_v : in0_v);
        out_d   = sel_d ? in1_d : in0_d;
        fire    = out_v & out_rdy;
        sel_rdy = fire;
        in0_rdy = fire & ~sel_d;
        in1_rdy = fire & sel_d;
    end
endmodule

// File: rtl/tok_ndmerge.sv
module tok_ndmerge #(
    parameter int W = 8
) (
    input  logic [W-1:0] in0_d,
    input  logic         in0_v,
    output logic         in0_rdy,
    input  logic [W-1:0] in1_d,
    input  logic         in1_v,
    output logic         in1_rdy,
    output logic [W-1:0] out_d,
    output logic         out_v,
    input  logic         out_rdy
);
    always_comb begin
        out_v   = in0_v | in1_v;
        out_d   = in0_v ? in0_d : in1_d;
        in0_rdy = out_rdy & in0_v;
        in1_rdy = out_rdy & in1_v & ~in0_v;
    end
endmodule

// File: rtl/tok_fanout.sv
module tok_fanout
    import tok_pkg::*;
#(
    parameter int W  = 8,
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  a_d,
    input  logic          a_v,
    output logic          a_rdy,
    input  logic [W-1:0]  b_d,
    input  logic          b_v,
    output logic          b_rdy,
    output logic [W-1:0]  out_d,
    output logic [NF-1:0] out_v,
    input  logic [NF-1:0] out_rdy
);
    fo_state_t     state, state_nx;
    logic [W-1:0]  res_q;
    logic [NF-1:0] done_q;
    logic [NF-1:0] take;
    logic          fire;
    logic          finish;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FO_IDLE;
            res_q  <= '0;
            done_q <= '0;
        end else begin
            state <= state_nx;
            if (fire) begin
                res_q  <= a_d + b_d;
                done_q <= '0;
            end else if (state == FO_EMIT) begin
                done_q <= done_q | take;
            end
        end
    end

    always_comb begin
        fire     = 1'b0;
        finish   = 1'b0;
        out_v    = '0;
        take     = '0;
        state_nx = state;
        unique case (state)
            FO_IDLE: begin
                fire = a_v & b_v;
                if (fire) state_nx = FO_EMIT;
            end
            FO_EMIT: begin
                out_v  = ~done_q;
                take   = out_v & out_rdy;
                finish = &(done_q | take);
                if (finish) state_nx = FO_IDLE;
            end
            default: state_nx = FO_IDLE;
        endcase
        a_rdy = fire;
        b_rdy = fire;
        out_d = res_q;
    end
endmodule

// File: rtl/tok_steer_top.sv
module tok_steer_top #(
    parameter int W  = 8,
    parameter int NV = 2,
    parameter int NF = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NV-1:0][W-1:0] br_val_d,
    input  logic [NV-1:0]        br_val_v,
    output logic [NV-1:0]        br_val_rdy,
    input  logic                 br_ctl_d,
    input  logic                 br_ctl_v,
    output logic                 br_ctl_rdy,
    output logic [NV-1:0][W-1:0] br_t_d,
    output logic                 br_t_v,
    input  logic                 br_t_rdy,
    output logic [NV-1:0][W-1:0] br_f_d,
    output logic                 br_f_v,
    input  logic                 br_f_rdy,
    input  logic [W-1:0]         dm_in0_d,
    input  logic                 dm_in0_v,
    output logic                 dm_in0_rdy,
    input  logic [W-1:0]         dm_in1_d,
    input  logic                 dm_in1_v,
    output logic                 dm_in1_rdy,
    input  logic                 dm_sel_d,
    input  logic                 dm_sel_v,
    output logic                 dm_sel_rdy,
    output logic [W-1:0]         dm_out_d,
    output logic                 dm_out_v,
    input  logic                 dm_out_rdy,
    input  logic [W-1:0]         nd_in0_d,
    input  logic                 nd_in0_v,
    output logic                 nd_in0_rdy,
    input  logic [W-1:0]         nd_in1_d,
    input  logic                 nd_in1_v,
    output logic                 nd_in1_rdy,
    output logic [W-1:0]         nd_out_d,
    output logic                 nd_out_v,
    input  logic                 nd_out_rdy,
    input  logic [W-1:0]         fo_a_d,
    input  logic                 fo_a_v,
    output logic                 fo_a_rdy,
    input  logic [W-1:0]         fo_b_d,
    input  logic                 fo_b_v,
    output logic                 fo_b_rdy,
    output logic [W-1:0]         fo_out_d,
    output logic [NF-1:0]        fo_out_v,
    input  logic [NF-1:0]        fo_out_rdy
);
    tok_branch #(.W(W), .NV(NV)) u_branch (
        .val_d(br_val_d), .val_v(br_val_v), .val_rdy(br_val_rdy),
        .ctl_d(br_ctl_d), .ctl_v(br_ctl_v), .ctl_rdy(br_ctl_rdy),
        .t_d(br_t_d), .t_v(br_t_v), .t_rdy(br_t_rdy),
        .f_d(br_f_d), .f_v(br_f_v), .f_rdy(br_f_rdy)
    );

    tok_dmerge #(.W(W)) u_dmerge (
        .in0_d(dm_in0_d), .in0_v(dm_in0_v), .in0_rdy(dm_in0_rdy),
        .in1_d(dm_in1_d), .in1_v(dm_in1_v), .in1_rdy(dm_in1_rdy),
        .sel_d(dm_sel_d), .sel_v(dm_sel_v), .sel_rdy(dm_sel_rdy),
        .out_d(dm_out_d), .out_v(dm_out_v), .out_rdy(dm_out_rdy)
    );

    tok_ndmerge #(.W(W)) u_ndmerge (
        .in0_d(nd_in0_d), .in0_v(nd_in0_v), .in0_rdy(nd_in0_rdy),
        .in1_d(nd_in1_d), .in1_v(nd_in1_v), .in1_rdy(nd_in1_rdy),
        .out_d(nd_out_d), .out_v(nd_out_v), .out_rdy(nd_out_rdy)
    );

    tok_fanout #(.W(W), .NF(NF)) u_fanout (
        .clk(clk), .rst_n(rst_n),
        .a_d(fo_a_d), .a_v(fo_a_v), .a_rdy(fo_a_rdy),
        .b_d(fo_b_d), .b_v(fo_b_v), .b_rdy(fo_b_rdy),
        .out_d(fo_out_d), .out_v(fo_out_v), .out_rdy(fo_out_rdy)
    );
endmodule

// File: rtl/tok_steer_chk.sv
module tok_steer_chk #(
    parameter int W  = 8,
    parameter int NV = 2,
    parameter int NF = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NV-1:0]        br_val_v,
    input logic                 br_ctl_v,
    input logic                 br_ctl_rdy,
    input logic                 br_t_v,
    input logic                 br_f_v,
    input logic                 dm_in0_v,
    input logic                 dm_in1_v,
    input logic                 dm_sel_d,
    input logic                 dm_sel_v,
    input logic                 dm_sel_rdy,
    input logic                 nd_in0_v,
    input logic                 nd_in1_v,
    input logic                 nd_in1_rdy,
    input logic                 fo_a_v,
    input logic                 fo_b_v,
    input logic                 fo_a_rdy,
    input logic                 fo_b_rdy,
    input logic [W-1:0]         fo_out_d,
    input logic [NF-1:0]        fo_out_v,
    input logic [NF-1:0]        fo_out_rdy
);
    AST_BR_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_t_v && br_f_v)); // R3

    AST_BR_FULL_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
        br_ctl_rdy |-> (br_ctl_v && (&br_val_v))); // R4

    AST_DM_PICKED: assert property (@(posedge clk) disable iff (!rst_n)
        dm_sel_rdy |-> (dm_sel_v && (dm_sel_d ? dm_in1_v : dm_in0_v))); // R6

    AST_ND_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (nd_in0_v && nd_in1_v) |-> !nd_in1_rdy); // R7

    AST_FO_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (fo_a_rdy || fo_b_rdy) |-> (fo_a_rdy && fo_b_rdy && fo_a_v && fo_b_v)); // R2

    AST_FO_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (|fo_out_v) |-> !fo_a_rdy); // R9

    for (genvar i = 0; i < NF; i++) begin : g_out
        AST_FO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (fo_out_v[i] && !fo_out_rdy[i]) |=> (fo_out_v[i] && $stable(fo_out_d))); // R8
        AST_FO_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
            (fo_out_v[i] && fo_out_rdy[i]) |=> !fo_out_v[i]); // R8
    end
endmodule

bind tok_steer_top tok_steer_chk #(.W(W), .NV(NV), .NF(NF)) u_chk (.*);

// File: tb/tb_tok_steer_top.sv
module tb_tok_steer_top;
    localparam int W  = 8;
    localparam int NV = 2;
    localparam int NF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [NV-1:0][W-1:0] br_val_d, br_t_d, br_f_d;
    logic [NV-1:0] br_val_v, br_val_rdy;
    logic br_ctl_d, br_ctl_v, br_ctl_rdy, br_t_v, br_t_rdy, br_f_v, br_f_rdy;
    logic [W-1:0] dm_in0_d, dm_in1_d, dm_out_d;
    logic dm_in0_v, dm_in0_rdy, dm_in1_v, dm_in1_rdy, dm_sel_d, dm_sel_v, dm_sel_rdy;
    logic dm_out_v, dm_out_rdy;
    logic [W-1:0] nd_in0_d, nd_in1_d, nd_out_d;
    logic nd_in0_v, nd_in0_rdy, nd_in1_v, nd_in1_rdy, nd_out_v, nd_out_rdy;
    logic [W-1:0] fo_a_d, fo_b_d, fo_out_d;
    logic fo_a_v, fo_a_rdy, fo_b_v, fo_b_rdy;
    logic [NF-1:0] fo_out_v, fo_out_rdy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    tok_steer_top #(.W(W), .NV(NV), .NF(NF)) dut (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] br_exp(input logic [NV-1:0] vv, input logic cv, input logic cd,
                                          input logic tr, input logic fr);
        logic armed;
        logic fire;
        armed = (&vv) & cv;
        fire  = armed & (cd ? tr : fr);
        return {armed & cd, armed & ~cd, fire, fire};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] e;
        logic [W-1:0] sum;
        int got [NF];
        bit all_in;
        void'($urandom(32'h5eed_1234));
        br_val_d = '0; br_val_v = '0; br_ctl_d = 0; br_ctl_v = 0; br_t_rdy = 0; br_f_rdy = 0;
        dm_in0_d = 0; dm_in1_d = 0; dm_in0_v = 0; dm_in1_v = 0; dm_sel_d = 0; dm_sel_v = 0;
        dm_out_rdy = 0;
        nd_in0_d = 0; nd_in1_d = 0; nd_in0_v = 0; nd_in1_v = 0; nd_out_rdy = 0;
        fo_a_d = 0; fo_b_d = 0; fo_a_v = 0; fo_b_v = 0; fo_out_rdy = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk(fo_out_v == '0, "R1", fo_out_v, 0);
        chk(fo_a_rdy == 1'b0, "R1", fo_a_rdy, 0);

        // R3 R4 R5: random steering patterns
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            br_val_d = {$urandom, $urandom};
            br_val_v = (($urandom % 4) != 0) ? '1 : NV'($urandom);
            br_ctl_v = ($urandom % 4) != 0;
            br_ctl_d = $urandom;
            br_t_rdy = $urandom;
            br_f_rdy = $urandom;
            #2;
            e = br_exp(br_val_v, br_ctl_v, br_ctl_d, br_t_rdy, br_f_rdy);
            chk({br_t_v, br_f_v} == e[3:2], "R3", {br_t_v, br_f_v}, e[3:2]);
            chk(br_ctl_rdy == e[1], "R4", br_ctl_rdy, e[1]);
            chk(br_val_rdy == {NV{e[0]}}, "R4", br_val_rdy, {NV{e[0]}});
            if (br_t_v) chk(br_t_d == br_val_d, "R3", br_t_d, br_val_d);
            if (br_f_v) chk(br_f_d == br_val_d, "R3", br_f_d, br_val_d);
        end
        // R5 directed: true picked, only false ready
        @(negedge clk);
        br_val_v = '1; br_ctl_v = 1; br_ctl_d = 1; br_t_rdy = 0; br_f_rdy = 1;
        #2;
        chk(br_ctl_rdy == 0 && br_val_rdy == '0, "R5", {br_ctl_rdy, br_val_rdy}, 0);
        // R4 directed: one lane missing
        @(negedge clk);
        br_val_v = 2'b01; br_t_rdy = 1;
        #2;
        chk(br_ctl_rdy == 0 && br_t_v == 0, "R4", {br_ctl_rdy, br_t_v}, 0);
        @(negedge clk);
        br_val_v = '0; br_ctl_v = 0;

        // R6: selected joiner random
        for (int k = 0; k < 150; k++) begin
            logic ev;
            logic [W-1:0] ed;
            @(negedge clk);
            dm_in0_d = $urandom; dm_in1_d = $urandom;
            dm_in0_v = $urandom; dm_in1_v = $urandom;
            dm_sel_d = $urandom; dm_sel_v = ($urandom % 4) != 0;
            dm_out_rdy = $urandom;
            #2;
            ev = dm_sel_v & (dm_sel_d ? dm_in1_v : dm_in0_v);
            ed = dm_sel_d ? dm_in1_d : dm_in0_d;
            chk(dm_out_v == ev, "R6", dm_out_v, ev);
            if (ev) chk(dm_out_d == ed, "R6", dm_out_d, ed);
            chk(dm_in0_rdy == (ev & dm_out_rdy & ~dm_sel_d), "R6", dm_in0_rdy, ev & dm_out_rdy & ~dm_sel_d);
            chk(dm_in1_rdy == (ev & dm_out_rdy & dm_sel_d), "R6", dm_in1_rdy, ev & dm_out_rdy & dm_sel_d);
            chk(dm_sel_rdy == (ev & dm_out_rdy), "R6", dm_sel_rdy, ev & dm_out_rdy);
        end
        @(negedge clk);
        dm_sel_v = 0;

        // R7: first-come joiner random
        for (int k = 0; k < 150; k++) begin
            @(negedge clk);
            nd_in0_d = $urandom; nd_in1_d = $urandom;
            nd_in0_v = $urandom; nd_in1_v = $urandom; nd_out_rdy = $urandom;
            #2;
            chk(nd_out_v == (nd_in0_v | nd_in1_v), "R7", nd_out_v, nd_in0_v | nd_in1_v);
            if (nd_in0_v) chk(nd_out_d == nd_in0_d, "R7", nd_out_d, nd_in0_d);
            else if (nd_in1_v) chk(nd_out_d == nd_in1_d, "R7", nd_out_d, nd_in1_d);
            chk(nd_in1_rdy == (nd_out_rdy & nd_in1_v & ~nd_in0_v), "R7", nd_in1_rdy,
                nd_out_rdy & nd_in1_v & ~nd_in0_v);
        end
        // R7 directed: both pending, input 0 then input 1
        @(negedge clk);
        nd_in0_d = 8'hA1; nd_in1_d = 8'hB2; nd_in0_v = 1; nd_in1_v = 1; nd_out_rdy = 1;
        #2;
        chk(nd_out_d == 8'hA1 && nd_in0_rdy && !nd_in1_rdy, "R7", nd_out_d, 8'hA1);
        @(negedge clk);
        nd_in0_v = 0;
        #2;
        chk(nd_out_d == 8'hB2 && nd_in1_rdy, "R7", nd_out_d, 8'hB2);
        @(negedge clk);
        nd_in1_v = 0;

        // R2 directed: one operand alone is not consumed
        fo_a_d = 8'h11; fo_a_v = 1;
        #2;
        chk(fo_a_rdy == 0 && fo_b_rdy == 0, "R2", {fo_a_rdy, fo_b_rdy}, 0);
        @(negedge clk); #2;
        chk(fo_out_v == '0, "R2", fo_out_v, 0);

        // R8 R9: fan-out firings with random consumer backpressure
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            fo_a_d = (k == 0) ? 8'hFF : W'($urandom);
            fo_b_d = (k == 0) ? 8'h03 : W'($urandom);
            fo_a_v = 1; fo_b_v = 1; fo_out_rdy = '0;
            sum = fo_a_d + fo_b_d;
            #2;
            chk(fo_a_rdy && fo_b_rdy, "R2", {fo_a_rdy, fo_b_rdy}, 2'b11);
            @(negedge clk);
            fo_a_d = ~fo_a_d;
            for (int i = 0; i < NF; i++) got[i] = 0;
            all_in = 0;
            while (!all_in) begin
                fo_out_rdy = NF'($urandom);
                #2;
                chk(fo_a_rdy == 0, "R9", fo_a_rdy, 0);
                for (int i = 0; i < NF; i++) begin
                    if (fo_out_v[i]) chk(fo_out_d == sum, "R8", fo_out_d, sum);
                    if (fo_out_v[i] && fo_out_rdy[i]) got[i]++;
                end
                all_in = 1;
                for (int i = 0; i < NF; i++) if (got[i] == 0) all_in = 0;
                if (all_in) fo_a_v = 0;
                @(negedge clk);
                if (all_in) fo_b_v = 0;
            end
            fo_a_v = 0; fo_b_v = 0; fo_out_rdy = '1;
            #2;
            chk(fo_out_v == '0, "R8", fo_out_v, 0);
            for (int i = 0; i < NF; i++) chk(got[i] == 1, "R8", got[i], 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule